// File: doc/BRIEF.md
# Dual Polled Interval Timers

This block holds two interval timers, A and B, that a host sets up with 8-bit register writes and watches by reading a status byte. Both count down from a period derived from a reload value. When a timer's count runs out it reloads itself and keeps going for as long as its start bit stays set. At each expiry it can latch an overflow flag. Nothing is signalled to the host on its own: the host polls the flags and clears them by writing the control register.

Timer A takes a 10-bit reload value that spans two registers. The high byte is held in a staging register, and the complete value changes only when the low part is written afterwards. Timer A counts one step per pulse of the base tick enable. Timer B takes an 8-bit reload value and counts one step per sixteen base ticks, through a prescaler that restarts whenever B is started. Each timer is a two-state machine. In IDLE the counter is held. The transition START (start bit seen as 1) moves it to RUN and loads the full period. In RUN, the transition EXPIRE (a tick while the count is 1) reloads the period and raises an overflow event, and the transition STOP (start bit seen as 0) returns it to IDLE.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both flags and the whole status byte are 0 and both timers are idle: ticks alone never set a flag.
- R2: Address 0x24 stages bits 9..2 of Timer A's value, and address 0x25 bits 1..0 commit the staged byte together with those two bits. A write to 0x24 alone leaves the active Timer A value unchanged.
- R3: Once started, Timer A expires after exactly 1024 − value base ticks and then again every 1024 − value ticks while its start bit stays 1.
- R4: Address 0x26 holds Timer B's 8-bit value. Once started, Timer B expires after exactly 16 × (256 − value) base ticks.
- R5: In the control register at 0x27, bit 0 starts Timer A and bit 1 starts Timer B. A start bit going from 0 to 1 begins a fresh period. Writing 1 again while the timer runs does not restart it, and writing 0 stops it so that it never expires.
- R6: Control bit 2 (A) and bit 3 (B) let an expiry set the matching flag. While the bit is 0 the flag is never set, but counting goes on.
- R7: Writing 1 to control bit 4 (A) or bit 5 (B) clears the matching flag. An expiry in the same cycle wins and leaves the flag set.
- R8: The status byte carries Timer A's flag in bit 0 and Timer B's flag in bit 1, with bits 7..2 always 0. The flags also appear on their own outputs.
- R9: A new reload value written while a timer runs does not shorten the current period. It takes effect at the next reload.
- R10: Writes to any other address change neither flag nor any timer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Base tick enable pulse, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| status | output | 8 | Polled status byte |
| flag_a | output | 1 | Timer A overflow flag |
| flag_b | output | 1 | Timer B overflow flag |

## Verification
The bench builds the block with its default widths: a 10-bit Timer A, an 8-bit Timer B and a divide-by-16 prescaler. It programs reload values close to the top of each range (1018 to 1022 for A, 254 and 255 for B), so periods shrink to a handful of ticks. Each expiry can then be checked on the exact tick, one tick early and across several reloads within a short run. Because the widths stay at their defaults, Timer B's 16-tick spacing and the two-register write order of Timer A are exercised as they are built.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int A_WIDTH   = 10;
    localparam int B_WIDTH   = 8;
    localparam int B_DIVIDE  = 16;

    localparam logic [7:0] ADDR_A_HI = 8'h24;
    localparam logic [7:0] ADDR_A_LO = 8'h25;
    localparam logic [7:0] ADDR_B    = 8'h26;
    localparam logic [7:0] ADDR_CTRL = 8'h27;

    typedef enum logic {
        T_IDLE = 1'b0,
        T_RUN  = 1'b1
    } tmr_state_t;
endpackage

// File: rtl/dit_regs.sv
module dit_regs #(
    parameter int A_W = dit_pkg::A_WIDTH,
    parameter int B_W = dit_pkg::B_WIDTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [7:0]     wr_addr,
    input  logic [7:0]     wr_data,
    output logic [A_W-1:0] reload_a,
    output logic [B_W-1:0] reload_b,
    output logic           load_a,
    output logic           load_b,
    output logic           en_a,
    output logic           en_b,
    output logic           clr_a,
    output logic           clr_b
);
    import dit_pkg::*;

    localparam int LO_W = A_W - 8;

    logic [7:0] a_stage;
    logic       hit_hi, hit_lo, hit_b, hit_ctrl;

    assign hit_hi   = wr_en && (wr_addr == ADDR_A_HI);
    assign hit_lo   = wr_en && (wr_addr == ADDR_A_LO);
    assign hit_b    = wr_en && (wr_addr == ADDR_B);
    assign hit_ctrl = wr_en && (wr_addr == ADDR_CTRL);

    // Clear requests act in the write cycle and are not stored
    assign clr_a = hit_ctrl && wr_data[4];
    assign clr_b = hit_ctrl && wr_data[5];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_stage  <= '0;
            reload_a <= '0;
            reload_b <= '0;
            load_a   <= 1'b0;
            load_b   <= 1'b0;
            en_a     <= 1'b0;
            en_b     <= 1'b0;
        end else begin
            if (hit_hi) begin
                a_stage <= wr_data;
            end
            if (hit_lo) begin
                reload_a <= {a_stage, wr_data[LO_W-1:0]};
            end
            if (hit_b) begin
                reload_b <= wr_data[B_W-1:0];
            end
            if (hit_ctrl) begin
                load_a <= wr_data[0];
                load_b <= wr_data[1];
                en_a   <= wr_data[2];
                en_b   <= wr_data[3];
            end
        end
    end
endmodule

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
    parameter int DIV = dit_pkg::B_DIVIDE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick_in,
    output logic tick_out
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    assign tick_out = tick_in && (phase == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            phase <= '0;
        end else if (tick_in) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/dit_timer.sv
module dit_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic         enable,
    input  logic         clr,
    input  logic [W-1:0] reload,
    output logic         flag,
    output logic         ovf,
    output logic         running
);
    import dit_pkg::*;

    localparam int CW = W + 1;
    localparam logic [CW-1:0] SPAN = CW'(2 ** W);

    tmr_state_t    state, state_nx;
    logic [CW-1:0] count, count_nx, period;
    logic          flag_nx;

    assign period  = SPAN - {1'b0, reload};
    assign running = (state == T_RUN);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= T_IDLE;
            count <= '0;
            flag  <= 1'b0;
        end else begin
            state <= state_nx;
            count <= count_nx;
            flag  <= flag_nx;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_nx = state;
        count_nx = count;
        ovf      = 1'b0;
        unique case (state)
            T_IDLE: begin
                if (load) begin
                    state_nx = T_RUN;     // START
                    count_nx = period;
                end
            end
            T_RUN: begin
                if (!load) begin
                    state_nx = T_IDLE;    // STOP
                end else if (tick) begin
                    if (count == CW'(1)) begin
                        ovf      = 1'b1;  // EXPIRE
                        count_nx = period;
                    end else begin
                        count_nx = count - 1'b1;
                    end
                end
            end
            default: state_nx = T_IDLE;
        endcase
        flag_nx = flag;
        if (clr) begin
            flag_nx = 1'b0;
        end
        if (ovf && enable) begin
            flag_nx = 1'b1;
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
    parameter int A_W = dit_pkg::A_WIDTH,
    parameter int B_W = dit_pkg::B_WIDTH,
    parameter int B_DIV = dit_pkg::B_DIVIDE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] status,
    output logic       flag_a,
    output logic       flag_b
);
    logic [A_W-1:0] reload_a;
    logic [B_W-1:0] reload_b;
    logic load_a, load_b, en_a, en_b, clr_a, clr_b;
    logic ovf_a, ovf_b, run_a, run_b, b_tick;

    dit_regs #(.A_W(A_W), .B_W(B_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .reload_a(reload_a), .reload_b(reload_b),
        .load_a(load_a), .load_b(load_b),
        .en_a(en_a), .en_b(en_b),
        .clr_a(clr_a), .clr_b(clr_b)
    );

    dit_timer #(.W(A_W)) u_tmr_a (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .load(load_a), .enable(en_a), .clr(clr_a), .reload(reload_a),
        .flag(flag_a), .ovf(ovf_a), .running(run_a)
    );

    dit_prescaler #(.DIV(B_DIV)) u_pre_b (
        .clk(clk), .rst_n(rst_n), .hold(!run_b),
        .tick_in(tick_en), .tick_out(b_tick)
    );

    dit_timer #(.W(B_W)) u_tmr_b (
        .clk(clk), .rst_n(rst_n), .tick(b_tick),
        .load(load_b), .enable(en_b), .clr(clr_b), .reload(reload_b),
        .flag(flag_b), .ovf(ovf_b), .running(run_b)
    );

    assign status = {6'b0, flag_b, flag_a};
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
    parameter int A_W = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_en,
    input logic           wr_en,
    input logic [7:0]     wr_addr,
    input logic [A_W-1:0] reload_a,
    input logic           en_a,
    input logic           clr_a,
    input logic           ovf_a,
    input logic           run_a,
    input logic           flag_a,
    input logic           b_tick,
    input logic           run_b,
    input logic           ovf_b,
    input logic           clr_b,
    input logic           flag_b
);
    // R2
    a_hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h24) |=> $stable(reload_a));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_a |-> !ovf_a) and (!run_b |-> !ovf_b));

    // R6
    flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> $past(en_a));

    // R7
    clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && !ovf_a) |=> !flag_a);

    // R7
    clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_b && !ovf_b) |=> !flag_b);

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_a && !clr_a) |=> $stable(flag_a));

    // R4
    b_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_tick |-> (tick_en && run_b));
endmodule

bind dual_interval_timer dit_checker #(.A_W(A_W)) u_dit_checker (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .reload_a(reload_a),
    .en_a(en_a), .clr_a(clr_a), .ovf_a(ovf_a), .run_a(run_a),
    .flag_a(flag_a), .b_tick(b_tick), .run_b(run_b), .ovf_b(ovf_b),
    .clr_b(clr_b), .flag_b(flag_b)
);

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] status;
    logic       flag_a, flag_b;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dual_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .status(status), .flag_a(flag_a), .flag_b(flag_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic set_a(input logic [7:0] hi, input logic [7:0] lo);
        wr(8'h24, hi);
        wr(8'h25, lo);
    endtask

    task automatic t_reset();
        check("R1 status", status, 8'h00);
        ticks(40);
        check("R1 idle", status, 8'h00);
    endtask

    task automatic t_period_a();
        set_a(8'hFF, 8'h00);              // 1020 -> 4 ticks
        wr(8'h27, 8'h05);
        ticks(3);
        check("R3 early", {7'b0, flag_a}, 8'h00);
        ticks(1);
        check("R3 expire", {7'b0, flag_a}, 8'h01);
        check("R8 status A", status, 8'h01);
        wr(8'h27, 8'h15);                 // clear A, keep running
        check("R7 clear", {7'b0, flag_a}, 8'h00);
        ticks(3);
        check("R3 repeat early", {7'b0, flag_a}, 8'h00);
        ticks(1);
        check("R3 repeat", {7'b0, flag_a}, 8'h01);
        wr(8'h27, 8'h10);                 // stop and clear
    endtask

    task automatic t_order_a();
        set_a(8'hFF, 8'h01);              // 1021 -> 3 ticks
        wr(8'h24, 8'hFE);                 // staged only
        wr(8'h27, 8'h05);
        ticks(3);
        check("R2 high-only kept", {7'b0, flag_a}, 8'h01);
        wr(8'h27, 8'h10);
        wr(8'h25, 8'h02);                 // commits 1018 -> 6 ticks
        wr(8'h27, 8'h05);
        ticks(5);
        check("R2 commit early", {7'b0, flag_a}, 8'h00);
        ticks(1);
        check("R2 commit", {7'b0, flag_a}, 8'h01);
        wr(8'h27, 8'h10);
    endtask

    task automatic t_enable_restart();
        set_a(8'hFF, 8'h00);              // 4 ticks
        wr(8'h27, 8'h01);                 // run, flag disabled
        ticks(4);
        check("R6 disabled", {7'b0, flag_a}, 8'h00);
        wr(8'h27, 8'h05);                 // re-write start: no restart
        ticks(3);
        check("R5 no restart early", {7'b0, flag_a}, 8'h00);
        ticks(1);
        check("R5 no restart", {7'b0, flag_a}, 8'h01);
        wr(8'h27, 8'h14);                 // stop, clear
        ticks(12);
        check("R5 stopped", {7'b0, flag_a}, 8'h00);
    endtask

    task automatic t_same_cycle();
        wr(8'h27, 8'h05);
        ticks(4);
        ticks(3);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_addr = 8'h27; wr_data = 8'h15;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        check("R7 set wins", {7'b0, flag_a}, 8'h01);
        wr(8'h27, 8'h10);
    endtask

    task automatic t_reload_change();
        set_a(8'hFF, 8'h00);              // 4 ticks
        wr(8'h27, 8'h05);
        ticks(2);
        set_a(8'hFF, 8'h02);              // 1022 -> 2 ticks
        ticks(1);
        check("R9 current kept", {7'b0, flag_a}, 8'h00);
        ticks(1);
        check("R9 old period", {7'b0, flag_a}, 8'h01);
        wr(8'h27, 8'h15);
        ticks(1);
        check("R9 new early", {7'b0, flag_a}, 8'h00);
        ticks(1);
        check("R9 new period", {7'b0, flag_a}, 8'h01);
        wr(8'h27, 8'h10);
    endtask

    task automatic t_timer_b();
        wr(8'h26, 8'hFF);                 // 16 base ticks
        wr(8'h27, 8'h0A);
        ticks(15);
        check("R4 early", {7'b0, flag_b}, 8'h00);
        ticks(1);
        check("R4 expire", {7'b0, flag_b}, 8'h01);
        check("R8 status B", status, 8'h02);
        wr(8'h27, 8'h20);
        check("R7 clear B", status, 8'h00);
        wr(8'h26, 8'hFE);                 // 32 base ticks
        wr(8'h27, 8'h0A);
        ticks(31);
        check("R4 early 32", {7'b0, flag_b}, 8'h00);
        ticks(1);
        check("R4 expire 32", {7'b0, flag_b}, 8'h01);
    endtask

    task automatic t_other_addr();
        set_a(8'hFF, 8'h00);
        wr(8'h27, 8'h0F);                 // both running
        ticks(32);                        // both flags set
        wr(8'h27, 8'h0C);                 // stop, keep flags
        wr(8'h28, 8'h30);
        wr(8'h23, 8'h31);
        wr(8'h2B, 8'h00);
        check("R10 flags kept", status, 8'h03);
        wr(8'h27, 8'h05);
        ticks(3);
        wr(8'h27, 8'h15);
        check("R10 value kept early", {7'b0, flag_a}, 8'h00);
        ticks(1);
        check("R10 value kept", {7'b0, flag_a}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period_a();
        t_order_a();
        t_enable_restart();
        t_same_cycle();
        t_reload_change();
        t_timer_b();
        t_other_addr();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule